// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block picks the interrupt that a small 8-bit CPU core services next. Each of the maskable request lines has a 2-bit software priority field, held in byte-wide registers that software can write and read. The block compares these fields with the CPU's current 2-bit priority. When it accepts a request it raises a one-cycle acknowledge and gives the source index and the vector address. In the same cycle it loads the new CPU priority and saves the old one on a small internal stack. A software trap is non-maskable and outranks every maskable source. The CPU core also issues commands to the block: enable, disable, return, load-from-saved-flags and sleep. These set or restore the CPU priority.

Nesting depth is tracked by a three-state machine. `ST_MAIN` means no routine is active and the save stack is empty. `ST_NEST` means one or more routines are active and the stack has room. `ST_FULL` means the stack is full. The transitions are these. An accept moves `ST_MAIN` to `ST_NEST`, or to `ST_FULL` when the depth is one. An accept that fills the stack moves `ST_NEST` to `ST_FULL`. A return that empties the stack moves `ST_NEST` to `ST_MAIN`. A return moves `ST_FULL` back to `ST_NEST`, or to `ST_MAIN` when the depth is one. While the machine is in `ST_FULL`, every acceptance is held off.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Reset behaviour:
  - After reset, `cpu_pri` is 11 and `ack` and `ack_trap` are 0.
  - Every priority field is 11, so with the defaults registers 0 to 2 read FFh and register 3 reads 0Fh.
- R2: Priority codes and levels:
  - The 2-bit codes map to levels as follows: 10 is level 0, 01 is level 1, 00 is level 2 and 11 is level 3.
  - A pending maskable source is accepted only if its field's level is strictly greater than the level of `cpu_pri`.
- R3: Among eligible sources, the highest level wins, and on equal levels the lowest source index wins.
- R4: Acceptance outputs:
  - The edge that accepts source i sets `ack` to 1 for one cycle and `ack_src` to i.
  - `ack_vec` is FFFAh minus 2*i.
  - `cpu_pri` becomes the source's code.
- R5: Register layout:
  - Register k holds the fields of sources 4k to 4k+3, with source 4k+j at bits 2j+1:2j.
  - Bits with no source behind them read 0 and ignore writes.
  - `reg_rdata` shows the register selected by `reg_addr` in the same cycle.
- R6: A write of code 10 into a field leaves that field unchanged, while the other fields in the same byte are still written. Example: CFh written with 64h reads 44h.
- R7: Trap acceptance:
  - A pending `trap_req` is accepted in preference to any maskable source and whatever the CPU level.
  - It sets `ack` and `ack_trap`, loads `cpu_pri` with 11 and gives `ack_vec` FFFCh.
- R8: Command codes on `cmd_op`:
  - Enable (000) loads `cpu_pri` with 10.
  - Disable (001) loads `cpu_pri` with 11.
  - Sleep (100) loads `cpu_pri` with 10.
- R9: Return and flag-load commands:
  - Return (010) restores `cpu_pri` from the most recent save. When nothing is saved, return leaves `cpu_pri` unchanged.
  - Load-flags (011) copies `cc_pri_in` into `cpu_pri`.
  - Codes 101 to 111 do nothing.
- R10: In a cycle with `cmd_valid` high, nothing is accepted.
- R11: Each acceptance saves the old `cpu_pri`. Once DEPTH saves are outstanding, no acceptance, including a trap, happens until a return.
- R12: Priority change for the running source:
  - Raising the running source's field while it is still pending makes it accepted again.
  - Lowering the field leaves `cpu_pri` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Pending maskable request lines |
| trap_req | input | 1 | Software trap request, held until acknowledged |
| cmd_valid | input | 1 | A CPU priority command is present this cycle |
| cmd_op | input | 3 | Command code (see R8, R9) |
| cc_pri_in | input | 2 | Priority code for the load-flags command |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_trap | output | 1 | The acceptance is the trap |
| ack_src | output | SRC_W | Accepted source index |
| ack_vec | output | VEC_W | Vector address of the accepted request |
| cpu_pri | output | 2 | Current CPU priority code |

## Verification
The bench builds the block with its default parameters: fourteen sources and a four-entry save stack. With fourteen sources the last register is only half populated, so its dead upper bits and the vector address of the highest index (FFE0h) can be reached. With a depth of four, a held trap fills the stack in four cycles, so the `ST_FULL` hold-off and its release by a single return both occur. A behavioural model runs alongside directed sequences and a long random mix of requests, traps, commands and register writes.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [2:0] {
        OP_ENABLE  = 3'd0,
        OP_DISABLE = 3'd1,
        OP_RETURN  = 3'd2,
        OP_LOADCC  = 3'd3,
        OP_SLEEP   = 3'd4
    } nic_op_e;

    typedef enum logic [1:0] {
        ST_MAIN = 2'd0,
        ST_NEST = 2'd1,
        ST_FULL = 2'd2
    } nic_state_e;

    localparam logic [1:0] CODE_L0 = 2'b10;
    localparam logic [1:0] CODE_L1 = 2'b01;
    localparam logic [1:0] CODE_L2 = 2'b00;
    localparam logic [1:0] CODE_L3 = 2'b11;

    // Convert a stored priority code to its ordinal level.
    function automatic logic [1:0] code_to_lvl(input logic [1:0] code);
        unique case (code)
            CODE_L0: return 2'd0;
            CODE_L1: return 2'd1;
            CODE_L2: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Convert an ordinal level back to its stored code.
    function automatic logic [1:0] lvl_to_code(input logic [1:0] lvl);
        unique case (lvl)
            2'd0:    return CODE_L0;
            2'd1:    return CODE_L1;
            2'd2:    return CODE_L2;
            default: return CODE_L3;
        endcase
    endfunction

endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int REG_W   = 8,
    parameter int ADDR_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output logic [2*NUM_SRC-1:0]   fields
);
    localparam int PER_REG = REG_W / 2;

    logic [2*NUM_SRC-1:0] fld_q;
    logic [NUM_SRC-1:0]   hit;
    logic [2*NUM_SRC-1:0] wslice;

    // Per-field write qualification: right register, not the level-0 code.
    genvar g;
    for (g = 0; g < NUM_SRC; g++) begin : g_field
        localparam int RI = g / PER_REG;
        localparam int SL = g % PER_REG;
        assign wslice[2*g +: 2] = wdata[2*SL +: 2];
        assign hit[g] = we && (addr == ADDR_W'(RI)) && (wdata[2*SL +: 2] != CODE_L0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '1;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (hit[i]) begin
                    fld_q[2*i +: 2] <= wslice[2*i +: 2];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == ADDR_W'(i / PER_REG)) begin
                rdata[2*(i % PER_REG) +: 2] = fld_q[2*i +: 2];
            end
        end
    end

    assign fields = fld_q;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int SRC_W   = 4
) (
    input  logic [NUM_SRC-1:0]     req,
    input  logic [2*NUM_SRC-1:0]   fields,
    input  logic [1:0]             cur_code,
    output logic                   found,
    output logic [SRC_W-1:0]       win_idx,
    output logic [1:0]             win_code
);
    logic [1:0] cur_lvl;
    logic [1:0] lv;
    logic [1:0] win_lvl;

    // Scan upward; only a strictly higher level displaces the holder,
    // so equal levels keep the lower index.
    always_comb begin
        cur_lvl = code_to_lvl(cur_code);
        found   = 1'b0;
        win_idx = '0;
        win_lvl = 2'd0;
        lv      = 2'd0;
        for (int i = 0; i < NUM_SRC; i++) begin
            lv = code_to_lvl(fields[2*i +: 2]);
            if (req[i] && (lv > cur_lvl) && (!found || (lv > win_lvl))) begin
                found   = 1'b1;
                win_idx = SRC_W'(i);
                win_lvl = lv;
            end
        end
        win_code = lvl_to_code(win_lvl);
    end

endmodule

// File: rtl/nic_save_stack.sv
module nic_save_stack #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [1:0]       push_code,
    output logic [1:0]       top_code,
    output logic [CNT_W-1:0] count
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [1:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_ptr;

    assign top_ptr = cnt_q - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && (cnt_q != CNT_W'(DEPTH))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && (cnt_q != '0)) begin
            cnt_q <= top_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (push && (cnt_q != CNT_W'(DEPTH))) begin
            mem[cnt_q[IW-1:0]] <= push_code;
        end
    end

    assign top_code = mem[top_ptr[IW-1:0]];
    assign count    = cnt_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int               NUM_SRC  = 14,
    parameter int               DEPTH    = 4,
    parameter int               REG_W    = 8,
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'hFFFA,
    parameter logic [VEC_W-1:0] TRAP_VEC = 16'hFFFC,
    localparam int PER_REG  = REG_W / 2,
    localparam int NUM_REGS = (NUM_SRC + PER_REG - 1) / PER_REG,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               trap_req,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [1:0]         cc_pri_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               ack,
    output logic               ack_trap,
    output logic [SRC_W-1:0]   ack_src,
    output logic [VEC_W-1:0]   ack_vec,
    output logic [1:0]         cpu_pri
);
    nic_state_e           state_q, state_nx;
    nic_op_e              op;
    logic [2*NUM_SRC-1:0] fields;
    logic                 arb_found;
    logic [SRC_W-1:0]     arb_idx;
    logic [1:0]           arb_code;
    logic [1:0]           stk_top;
    logic [CNT_W-1:0]     stk_cnt;
    logic                 can_take, take_trap, take_src, push, pop;

    assign op = nic_op_e'(cmd_op);

    nic_prio_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .fields (fields)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .req      (irq_req),
        .fields   (fields),
        .cur_code (cpu_pri),
        .found    (arb_found),
        .win_idx  (arb_idx),
        .win_code (arb_code)
    );

    nic_save_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_code (cpu_pri),
        .top_code  (stk_top),
        .count     (stk_cnt)
    );

    // Decision: a command owns the cycle; otherwise trap beats maskable.
    always_comb begin
        can_take  = (state_q != ST_FULL);
        take_trap = !cmd_valid && can_take && trap_req;
        take_src  = !cmd_valid && can_take && !trap_req && arb_found;
        push      = take_trap || take_src;
        pop       = cmd_valid && (op == OP_RETURN) && (state_q != ST_MAIN);
    end

    // Nesting state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MAIN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_MAIN: begin
                if (push) state_nx = (DEPTH == 1) ? ST_FULL : ST_NEST;
            end
            ST_NEST: begin
                if (push && (stk_cnt == CNT_W'(DEPTH - 1))) state_nx = ST_FULL;
                else if (pop && (stk_cnt == CNT_W'(1)))     state_nx = ST_MAIN;
            end
            ST_FULL: begin
                if (pop) state_nx = (DEPTH == 1) ? ST_MAIN : ST_NEST;
            end
            default: state_nx = ST_MAIN;
        endcase
    end

    // Registered outputs and CPU priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            ack_trap <= 1'b0;
            ack_src  <= '0;
            ack_vec  <= '0;
            cpu_pri  <= CODE_L3;
        end else begin
            ack      <= push;
            ack_trap <= take_trap;
            if (take_trap) begin
                ack_src <= '0;
                ack_vec <= TRAP_VEC;
                cpu_pri <= CODE_L3;
            end else if (take_src) begin
                ack_src <= arb_idx;
                ack_vec <= VEC_BASE - VEC_W'({arb_idx, 1'b0});
                cpu_pri <= arb_code;
            end else if (cmd_valid) begin
                unique case (op)
                    OP_ENABLE:  cpu_pri <= CODE_L0;
                    OP_DISABLE: cpu_pri <= CODE_L3;
                    OP_RETURN:  if (state_q != ST_MAIN) cpu_pri <= stk_top;
                    OP_LOADCC:  cpu_pri <= cc_pri_in;
                    OP_SLEEP:   cpu_pri <= CODE_L0;
                    default:    cpu_pri <= cpu_pri;
                endcase
            end
        end
    end

endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int               NUM_SRC  = 14,
    parameter int               SRC_W    = 4,
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'hFFFA,
    parameter logic [VEC_W-1:0] TRAP_VEC = 16'hFFFC
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               trap_req,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic               ack,
    input logic               ack_trap,
    input logic [SRC_W-1:0]   ack_src,
    input logic [VEC_W-1:0]   ack_vec,
    input logic [1:0]         cpu_pri
);
    logic [NUM_SRC-1:0] req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_req;
    end

    p_level_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_trap) |-> (code_to_lvl(cpu_pri) > code_to_lvl($past(cpu_pri))));

    p_src_was_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_trap) |-> req_q[ack_src]);

    p_vector_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_trap) |-> (ack_vec == VEC_BASE - VEC_W'({ack_src, 1'b0})));

    p_trap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_trap |-> (ack && cpu_pri == 2'b11 && ack_vec == TRAP_VEC && $past(trap_req)));

    p_enable_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd0) |-> (cpu_pri == 2'b10));

    p_disable_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd1) |-> (cpu_pri == 2'b11));

    p_cmd_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid) |-> !ack);

endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_SRC  (NUM_SRC),
    .SRC_W    (SRC_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .TRAP_VEC (TRAP_VEC)
) u_nic_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .trap_req  (trap_req),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .ack       (ack),
    .ack_trap  (ack_trap),
    .ack_src   (ack_src),
    .ack_vec   (ack_vec),
    .cpu_pri   (cpu_pri)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;

    localparam int NS  = 14;
    localparam int DEP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] irq_req;
    logic          trap_req;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [1:0]    cc_pri_in;
    logic          reg_we;
    logic [1:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic          ack;
    logic          ack_trap;
    logic [3:0]    ack_src;
    logic [15:0]   ack_vec;
    logic [1:0]    cpu_pri;

    always #2 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .trap_req  (trap_req),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cc_pri_in (cc_pri_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack       (ack),
        .ack_trap  (ack_trap),
        .ack_src   (ack_src),
        .ack_vec   (ack_vec),
        .cpu_pri   (cpu_pri)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pri;
    int m_fld [NS];
    int m_stk [$];
    bit m_ack, m_trap;
    int m_src, m_vec;
    int best, blvl, fv;

    function automatic int lv(input int c);
        case (c)
            2: return 0;
            1: return 1;
            0: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int reg_model(input int a);
        int r = 0;
        for (int j = 0; j < 4; j++) begin
            if (4*a + j < NS) r |= m_fld[4*a + j] << (2*j);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pri = 3; m_ack = 0; m_trap = 0; m_src = 0; m_vec = 0;
            m_stk.delete();
            for (int i = 0; i < NS; i++) m_fld[i] = 3;
        end else begin
            m_ack = 0; m_trap = 0;
            if (cmd_valid) begin
                case (int'(cmd_op))
                    0: m_pri = 2;
                    1: m_pri = 3;
                    2: if (m_stk.size() > 0) m_pri = m_stk.pop_back();
                    3: m_pri = int'(cc_pri_in);
                    4: m_pri = 2;
                    default: ;
                endcase
            end else if (m_stk.size() < DEP) begin
                if (trap_req) begin
                    m_stk.push_back(m_pri);
                    m_pri = 3; m_ack = 1; m_trap = 1; m_vec = 16'hFFFC;
                end else begin
                    best = -1; blvl = -1;
                    for (int i = 0; i < NS; i++) begin
                        if (irq_req[i] && lv(m_fld[i]) > lv(m_pri) && lv(m_fld[i]) > blvl) begin
                            best = i; blvl = lv(m_fld[i]);
                        end
                    end
                    if (best >= 0) begin
                        m_stk.push_back(m_pri);
                        m_pri = m_fld[best]; m_ack = 1; m_src = best;
                        m_vec = 16'hFFFA - 2*best;
                    end
                end
            end
            if (reg_we) begin
                for (int j = 0; j < 4; j++) begin
                    fv = (int'(reg_wdata) >> (2*j)) & 3;
                    if (4*int'(reg_addr) + j < NS && fv != 2) m_fld[4*int'(reg_addr) + j] = fv;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int n_ack = 0, n_trap = 0, last_src = 0, last_vec = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ack == m_ack, tag, "ack", int'(ack), int'(m_ack));
            chk(ack_trap == m_trap, tag, "ack_trap", int'(ack_trap), int'(m_trap));
            chk(int'(cpu_pri) == m_pri, tag, "cpu_pri", int'(cpu_pri), m_pri);
            chk(int'(reg_rdata) == reg_model(int'(reg_addr)), tag, "reg_rdata",
                int'(reg_rdata), reg_model(int'(reg_addr)));
            if (m_ack) chk(int'(ack_vec) == m_vec, tag, "ack_vec", int'(ack_vec), m_vec);
            if (m_ack && !m_trap) chk(int'(ack_src) == m_src, tag, "ack_src", int'(ack_src), m_src);
            if (ack) begin
                n_ack++;
                if (ack_trap) n_trap++;
                last_src = int'(ack_src);
                last_vec = int'(ack_vec);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string t);
        @(posedge clk); #1;
        reg_addr = 2'(a);
        @(negedge clk);
        chk(int'(reg_rdata) == exp, t, "register readback", int'(reg_rdata), exp);
        @(posedge clk); #1;
    endtask

    task automatic cmd(input int op, input int cc);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 3'(op); cc_pri_in = 2'(cc);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(150000 * 4);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed and random sequences ----------------
    int base;

    initial begin
        rst_n = 1'b0; irq_req = '0; trap_req = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        cc_pri_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_pri == 2'b11, "R1", "cpu_pri after reset", int'(cpu_pri), 3);
        chk(ack == 1'b0 && ack_trap == 1'b0, "R1", "ack after reset", int'(ack), 0);
        idle(1);
        rd(0, 'hFF, "R1"); rd(1, 'hFF, "R1"); rd(2, 'hFF, "R1"); rd(3, 'h0F, "R1");

        tag = "R6";
        wr(0, 'hCF); rd(0, 'hCF, "R6");
        wr(0, 'h64); rd(0, 'h44, "R6");
        tag = "R5";
        wr(1, 'h00); wr(2, 'h55); wr(3, 'hFE);
        rd(1, 'h00, "R5"); rd(2, 'h55, "R5");
        rd(3, 'h0F, "R5");                      // src12 kept 11 (R6), dead bits read 0

        tag = "R3";
        irq_req = NS'((1 << 2) | (1 << 3) | (1 << 6) | (1 << 8));
        base = n_ack;
        cmd(0, 0); idle(3);
        chk(n_ack - base == 1, "R3", "accept count", n_ack - base, 1);
        chk(last_src == 2, "R3", "winner index", last_src, 2);
        chk(last_vec == 'hFFF6, "R4", "vector of source 2", last_vec, 'hFFF6);
        chk(cpu_pri == 2'b00, "R4", "cpu_pri after accept", int'(cpu_pri), 0);

        tag = "R4";
        base = n_ack;
        irq_req[12] = 1'b1; idle(3);
        chk(n_ack - base == 1 && last_src == 12, "R4", "source 12 accepted", last_src, 12);
        chk(last_vec == 'hFFE2, "R4", "vector of source 12", last_vec, 'hFFE2);
        tag = "R2";
        base = n_ack;
        irq_req[13] = 1'b1; idle(4);
        chk(n_ack == base, "R2", "equal level not accepted", n_ack - base, 0);

        tag = "R9";
        irq_req = '0;
        repeat (4) cmd(2, 0);
        chk(cpu_pri == 2'b10, "R9", "cpu_pri after returns", int'(cpu_pri), 2);

        tag = "R12";
        wr(1, 'h01);
        base = n_ack;
        irq_req = NS'(1 << 4); idle(3);
        chk(cpu_pri == 2'b01, "R12", "running at level 1", int'(cpu_pri), 1);
        wr(1, 'h03); idle(3);
        chk(n_ack - base == 2 && last_src == 4, "R12", "re-entry count", n_ack - base, 2);
        chk(cpu_pri == 2'b11, "R12", "cpu_pri after re-entry", int'(cpu_pri), 3);
        irq_req = '0;
        repeat (3) cmd(2, 0);
        wr(1, 'h00);
        base = n_ack;
        irq_req = NS'(1 << 4); idle(3);
        wr(1, 'h01); idle(3);
        chk(n_ack - base == 1, "R12", "lowering gives no re-entry", n_ack - base, 1);
        chk(cpu_pri == 2'b00, "R12", "cpu_pri kept on lowering", int'(cpu_pri), 0);
        irq_req = '0;
        repeat (3) cmd(2, 0);

        tag = "R7";
        base = n_ack;
        irq_req = NS'(1 << 12); trap_req = 1'b1; idle(8);
        chk(n_trap == 4 && n_ack - base == 4, "R7", "trap acceptances", n_ack - base, 4);
        chk(cpu_pri == 2'b11, "R7", "cpu_pri after trap", int'(cpu_pri), 3);
        chk(last_vec == 'hFFFC, "R7", "trap vector", last_vec, 'hFFFC);
        tag = "R11";
        trap_req = 1'b0;
        base = n_ack;
        cmd(2, 0); idle(3);
        chk(n_ack == base, "R11", "no accept after one return", n_ack - base, 0);
        trap_req = 1'b1; idle(6); trap_req = 1'b0;
        chk(n_ack - base == 1, "R11", "one slot after return", n_ack - base, 1);
        irq_req = '0;
        repeat (6) cmd(2, 0);
        chk(cpu_pri == 2'b10, "R9", "cpu_pri after unwinding", int'(cpu_pri), 2);

        tag = "R8";
        cmd(1, 0);
        chk(cpu_pri == 2'b11, "R8", "disable", int'(cpu_pri), 3);
        cmd(4, 0);
        chk(cpu_pri == 2'b10, "R8", "sleep", int'(cpu_pri), 2);
        tag = "R9";
        cmd(3, 1);
        chk(cpu_pri == 2'b01, "R9", "load flags", int'(cpu_pri), 1);
        cmd(6, 3);
        chk(cpu_pri == 2'b01, "R9", "unused code", int'(cpu_pri), 1);
        tag = "R8";
        cmd(0, 0);
        chk(cpu_pri == 2'b10, "R8", "enable", int'(cpu_pri), 2);

        tag = "R10";
        @(posedge clk); #1;
        irq_req = NS'(1 << 0); cmd_valid = 1'b1; cmd_op = 3'd0;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R10", "no accept in command cycle", int'(ack), 0);
        @(negedge clk);
        chk(ack == 1'b1 && ack_src == 4'd0, "R10", "accept one cycle later", int'(ack), 1);
        idle(1);
        irq_req = '0;
        cmd(2, 0);

        tag = "R2/R3 random";
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #1;
            irq_req   = NS'($urandom & $urandom);
            trap_req  = ($urandom_range(0, 15) == 0);
            cmd_valid = ($urandom_range(0, 5) == 0);
            cmd_op    = 3'($urandom_range(0, 5));
            cc_pri_in = 2'($urandom);
            reg_we    = ($urandom_range(0, 9) == 0);
            reg_addr  = 2'($urandom);
            reg_wdata = 8'($urandom);
        end
        @(posedge clk); #1;
        irq_req = '0; trap_req = 1'b0; cmd_valid = 1'b0; reg_we = 1'b0;
        idle(2);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule